// File: doc/BRIEF.md
# Battery Capacity Learning-Cycle Qualifier

This block decides whether a discharge of a lithium cell from full down to the first end-of-discharge voltage warning is trustworthy enough to re-learn the cell's full capacity. It arms a valid-discharge flag when the nominal available charge equals the last-measured capacity. While armed, it counts discharge, charge and self-discharge events. When the voltage warning first appears, it either publishes a new learned capacity with a one-cycle strobe or drops the attempt without publishing.

The block takes values and event strobes that are already digitised: capacity words, a signed temperature, average and standby current magnitudes, and single-cycle pulses for each counted quantity. It also keeps a capacity-inaccurate flag. A successful learn clears this flag. It re-asserts after 32 counted charge cycles without a learn, or after a reset that reports corrupted memory.

Top module: `learn_qualifier`

## Requirements
- R1: When `validDsg` is low and `nacIn` equals `lmdIn`, `validDsg` is high after the next clock edge, and the charge, self-discharge and discharge counts restart from zero.
- R2: While `validDsg` is high, the first cycle in which `edv1` is high after being low ends the attempt. `validDsg` is low after that edge. `capStrobe` is high for exactly one cycle after that edge when the attempt qualifies, and only then.
- R3: The published capacity is never below `lmdIn - (designCap >> 3)`, taken as 0 when that difference would be negative.
- R4: When it is above that floor, the published capacity equals the number of `dsgTick` pulses seen while armed.
- R5: A published capacity clears `capInacc` and restarts the count of cycles without a learn.
- R6: The 32nd `cycleTick` since the last learn or corrupt reset sets `capInacc`. The 31st does not.
- R7: A synchronous reset (`srstN` low) clears `validDsg`, `capStrobe` and `capOut`. A reset with `ramCorrupt` high sets `capInacc`. A reset with `ramCorrupt` low leaves `capInacc` unchanged.
- R8: A negative `tempIn` (two's complement) in the ending cycle disqualifies the attempt.
- R9: `avgCur <= 2*standbyCur` in the ending cycle disqualifies the attempt. `avgCur = 2*standbyCur + 1` does not.
- R10: The 256th `chgTick` while armed clears `validDsg`. The 255th does not.
- R11: The 64th `sdTick` while armed clears `validDsg`. The 63rd does not.
- R12: An `sdTick` in the ending cycle with `cacIn <= designCap >> 4` disqualifies the attempt. With `cacIn` one above that limit, the attempt still qualifies.
- R13: A disqualified or unarmed ending produces no strobe and leaves `capOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srstN | input | 1 | Synchronous reset, active low |
| ramCorrupt | input | 1 | Memory-corruption indication, sampled during reset |
| nacIn | input | CAP_W | Nominal available charge |
| lmdIn | input | CAP_W | Last-measured capacity |
| cacIn | input | CAP_W | Compensated available charge |
| designCap | input | CAP_W | Design capacity |
| edv1 | input | 1 | First end-of-discharge voltage flag (level) |
| tempIn | input | TEMP_W | Temperature, signed, 0 = 0 °C |
| avgCur | input | CUR_W | Average discharge current magnitude |
| standbyCur | input | CUR_W | Initial standby current magnitude |
| chgTick | input | 1 | One charge-count pulse |
| sdTick | input | 1 | One self-discharge reduction step |
| dsgTick | input | 1 | One discharge-count pulse |
| cycleTick | input | 1 | One charge cycle counted |
| validDsg | output | 1 | Valid-discharge flag |
| capInacc | output | 1 | Capacity-inaccurate flag |
| capOut | output | CAP_W | Learned capacity |
| capStrobe | output | 1 | One-cycle strobe marking a new `capOut` |

## Verification
Every result of this block is registered once. The flag changes from arming, counter exhaustion or an ending, the capacity and its strobe, and each change of `capInacc` all appear one clock edge after the edge that samples the causing input. The bench changes inputs just after a falling edge and advances a behavioural model on each rising edge. At every falling edge it compares all four outputs with that model, so each result is examined exactly in the cycle it is due. Directed checks at the same sampling points cover the boundary counts (255/256 charge, 63/64 self-discharge, 31/32 cycles) and the boundary current and charge limits.

// File: rtl/lq_pkg.sv
package lq_pkg;
  typedef struct packed {
    logic arm;     // start a new attempt, clear counts
    logic finish;  // armed attempt reaches its end point
    logic accept;  // ending qualifies: publish capacity
  } lqStrobe_t;
endpackage

// File: rtl/lq_satcnt.sv
module lq_satcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (clr)                q <= '0;
    else if (inc && q != '1) q <= q + 1'b1;
  end
endmodule

// File: rtl/lq_ctrl.sv
module lq_ctrl
  import lq_pkg::*;
(
  input  logic       clk,
  input  logic       srstN,
  input  logic       edv1,
  input  logic       nacEq,
  input  logic       coldNow,
  input  logic       lightNow,
  input  logic       chgOver,
  input  logic       sdLast,
  input  logic       sdTermLow,
  output logic       vdq,
  output lqStrobe_t  strb
);
  logic edvPrev;
  logic rise;
  logic spoil;

  assign rise  = edv1 & ~edvPrev;
  assign spoil = coldNow | lightNow | chgOver | sdLast | sdTermLow;

  always_comb begin
    strb.finish = vdq & rise;
    strb.accept = strb.finish & ~spoil;
    strb.arm    = ~vdq & nacEq;
  end

  always_ff @(posedge clk) begin
    if (!srstN) begin
      vdq     <= 1'b0;
      edvPrev <= 1'b0;
    end else begin
      edvPrev <= edv1;
      if (strb.finish)                 vdq <= 1'b0;
      else if (vdq && (chgOver || sdLast)) vdq <= 1'b0;
      else if (strb.arm)               vdq <= 1'b1;
    end
  end
endmodule

// File: rtl/lq_dp.sv
module lq_dp
  import lq_pkg::*;
#(
  parameter int CAP_W     = 16,
  parameter int TEMP_W    = 12,
  parameter int CUR_W     = 16,
  parameter int CHG_W     = 8,
  parameter int SD_W      = 7,
  parameter int SD_STEPS  = 64,
  parameter int CYC_LIMIT = 32
) (
  input  logic                     clk,
  input  logic                     srstN,
  input  logic                     ramCorrupt,
  input  logic [CAP_W-1:0]         nacIn,
  input  logic [CAP_W-1:0]         lmdIn,
  input  logic [CAP_W-1:0]         cacIn,
  input  logic [CAP_W-1:0]         designCap,
  input  logic signed [TEMP_W-1:0] tempIn,
  input  logic [CUR_W-1:0]         avgCur,
  input  logic [CUR_W-1:0]         standbyCur,
  input  logic                     chgTick,
  input  logic                     sdTick,
  input  logic                     dsgTick,
  input  logic                     cycleTick,
  input  logic                     vdq,
  input  lqStrobe_t                strb,
  output logic                     nacEq,
  output logic                     coldNow,
  output logic                     lightNow,
  output logic                     chgOver,
  output logic                     sdLast,
  output logic                     sdTermLow,
  output logic                     capInacc,
  output logic [CAP_W-1:0]         capOut,
  output logic                     capStrobe
);
  localparam int CYC_W = $clog2(CYC_LIMIT + 1);
  localparam logic [CHG_W-1:0] CHG_MAX  = '1;
  localparam logic [SD_W-1:0]  SD_FINAL = SD_W'(SD_STEPS - 1);
  localparam logic [CYC_W-1:0] CYC_TOP  = CYC_W'(CYC_LIMIT);
  localparam logic [CYC_W-1:0] CYC_PRE  = CYC_W'(CYC_LIMIT - 1);

  logic             cntClr;
  logic [CHG_W-1:0] chgCnt;
  logic [SD_W-1:0]  sdCnt;
  logic [CAP_W-1:0] dsgAcc;
  logic [CYC_W-1:0] cycCnt;
  logic [CAP_W-1:0] dcEighth;
  logic [CAP_W-1:0] floorVal;
  logic [CAP_W-1:0] learned;

  assign cntClr = ~srstN | strb.arm;

  lq_satcnt #(.W(CHG_W)) u_chgCnt (.clk(clk), .clr(cntClr), .inc(vdq & chgTick), .q(chgCnt));
  lq_satcnt #(.W(SD_W))  u_sdCnt  (.clk(clk), .clr(cntClr), .inc(vdq & sdTick),  .q(sdCnt));
  lq_satcnt #(.W(CAP_W)) u_dsgAcc (.clk(clk), .clr(cntClr), .inc(vdq & dsgTick), .q(dsgAcc));

  always_comb begin
    nacEq     = (nacIn == lmdIn);
    coldNow   = tempIn[TEMP_W-1];
    lightNow  = {1'b0, avgCur} <= {standbyCur, 1'b0};
    chgOver   = chgTick & (chgCnt == CHG_MAX);
    sdLast    = sdTick & (sdCnt == SD_FINAL);
    sdTermLow = sdTick & (cacIn <= (designCap >> 4));
    dcEighth  = designCap >> 3;
    floorVal  = (lmdIn > dcEighth) ? (lmdIn - dcEighth) : '0;
    learned   = (dsgAcc > floorVal) ? dsgAcc : floorVal;
  end

  always_ff @(posedge clk) begin
    if (!srstN) begin
      capOut    <= '0;
      capStrobe <= 1'b0;
    end else begin
      capStrobe <= strb.accept;
      if (strb.accept) capOut <= learned;
    end
  end

  always_ff @(posedge clk) begin
    if (!srstN) begin
      if (ramCorrupt) begin
        capInacc <= 1'b1;
        cycCnt   <= '0;
      end
    end else if (strb.accept) begin
      capInacc <= 1'b0;
      cycCnt   <= '0;
    end else if (cycleTick && cycCnt != CYC_TOP) begin
      cycCnt <= cycCnt + 1'b1;
      if (cycCnt == CYC_PRE) capInacc <= 1'b1;
    end
  end
endmodule

// File: rtl/learn_qualifier.sv
module learn_qualifier
  import lq_pkg::*;
#(
  parameter int CAP_W     = 16,
  parameter int TEMP_W    = 12,
  parameter int CUR_W     = 16,
  parameter int CHG_W     = 8,
  parameter int SD_W      = 7,
  parameter int SD_STEPS  = 64,
  parameter int CYC_LIMIT = 32
) (
  input  logic                     clk,
  input  logic                     srstN,
  input  logic                     ramCorrupt,
  input  logic [CAP_W-1:0]         nacIn,
  input  logic [CAP_W-1:0]         lmdIn,
  input  logic [CAP_W-1:0]         cacIn,
  input  logic [CAP_W-1:0]         designCap,
  input  logic                     edv1,
  input  logic signed [TEMP_W-1:0] tempIn,
  input  logic [CUR_W-1:0]         avgCur,
  input  logic [CUR_W-1:0]         standbyCur,
  input  logic                     chgTick,
  input  logic                     sdTick,
  input  logic                     dsgTick,
  input  logic                     cycleTick,
  output logic                     validDsg,
  output logic                     capInacc,
  output logic [CAP_W-1:0]         capOut,
  output logic                     capStrobe
);
  lqStrobe_t strb;
  logic nacEq, coldNow, lightNow, chgOver, sdLast, sdTermLow;

  lq_ctrl u_ctrl (
    .clk(clk), .srstN(srstN), .edv1(edv1), .nacEq(nacEq),
    .coldNow(coldNow), .lightNow(lightNow), .chgOver(chgOver),
    .sdLast(sdLast), .sdTermLow(sdTermLow), .vdq(validDsg), .strb(strb)
  );

  lq_dp #(
    .CAP_W(CAP_W), .TEMP_W(TEMP_W), .CUR_W(CUR_W), .CHG_W(CHG_W),
    .SD_W(SD_W), .SD_STEPS(SD_STEPS), .CYC_LIMIT(CYC_LIMIT)
  ) u_dp (
    .clk(clk), .srstN(srstN), .ramCorrupt(ramCorrupt),
    .nacIn(nacIn), .lmdIn(lmdIn), .cacIn(cacIn), .designCap(designCap),
    .tempIn(tempIn), .avgCur(avgCur), .standbyCur(standbyCur),
    .chgTick(chgTick), .sdTick(sdTick), .dsgTick(dsgTick), .cycleTick(cycleTick),
    .vdq(validDsg), .strb(strb),
    .nacEq(nacEq), .coldNow(coldNow), .lightNow(lightNow), .chgOver(chgOver),
    .sdLast(sdLast), .sdTermLow(sdTermLow),
    .capInacc(capInacc), .capOut(capOut), .capStrobe(capStrobe)
  );
endmodule

// File: rtl/learn_qualifier_chk.sv
module learn_qualifier_chk #(
  parameter int CAP_W  = 16,
  parameter int TEMP_W = 12,
  parameter int CUR_W  = 16
) (
  input logic                     clk,
  input logic                     srstN,
  input logic [CAP_W-1:0]         nacIn,
  input logic [CAP_W-1:0]         lmdIn,
  input logic [CAP_W-1:0]         designCap,
  input logic                     edv1,
  input logic signed [TEMP_W-1:0] tempIn,
  input logic [CUR_W-1:0]         avgCur,
  input logic [CUR_W-1:0]         standbyCur,
  input logic                     validDsg,
  input logic                     capInacc,
  input logic [CAP_W-1:0]         capOut,
  input logic                     capStrobe
);
  // R1: equality while idle arms the flag
  p_arm_r1: assert property (@(posedge clk) disable iff (!srstN)
    (!validDsg && nacIn == lmdIn) |=> validDsg);

  // R2: strobe lasts one cycle and follows an armed state
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!srstN)
    capStrobe |=> !capStrobe);
  p_strobe_after_arm_r2: assert property (@(posedge clk) disable iff (!srstN)
    capStrobe |-> ($past(validDsg) && !validDsg));

  // R3: learn-down floor
  p_floor_r3: assert property (@(posedge clk) disable iff (!srstN)
    capStrobe |-> ({1'b0, capOut} + {4'b0, $past(designCap) >> 3} >= {1'b0, $past(lmdIn)}));

  // R5: a publish leaves the inaccuracy flag clear
  p_ci_clear_r5: assert property (@(posedge clk) disable iff (!srstN)
    capStrobe |-> !capInacc);

  // R8: cold ending never publishes
  p_cold_r8: assert property (@(posedge clk) disable iff (!srstN)
    (validDsg && edv1 && tempIn < 0) |=> !capStrobe);

  // R9: light load ending never publishes
  p_light_r9: assert property (@(posedge clk) disable iff (!srstN)
    (validDsg && edv1 && ({1'b0, avgCur} <= {standbyCur, 1'b0})) |=> !capStrobe);
endmodule

bind learn_qualifier learn_qualifier_chk #(
  .CAP_W(CAP_W), .TEMP_W(TEMP_W), .CUR_W(CUR_W)
) u_chk (
  .clk(clk), .srstN(srstN), .nacIn(nacIn), .lmdIn(lmdIn), .designCap(designCap),
  .edv1(edv1), .tempIn(tempIn), .avgCur(avgCur), .standbyCur(standbyCur),
  .validDsg(validDsg), .capInacc(capInacc), .capOut(capOut), .capStrobe(capStrobe)
);

// File: tb/learn_qualifier_test.sv
module learn_qualifier_test;
  localparam int CLK_PERIOD = 10;
  localparam int CAP_W = 16;
  localparam int TEMP_W = 12;
  localparam int CUR_W = 16;

  logic clk = 1'b0;
  logic srstN, ramCorrupt;
  logic [CAP_W-1:0] nacIn, lmdIn, cacIn, designCap;
  logic edv1;
  logic signed [TEMP_W-1:0] tempIn;
  logic [CUR_W-1:0] avgCur, standbyCur;
  logic chgTick, sdTick, dsgTick, cycleTick;
  logic validDsg, capInacc, capStrobe;
  logic [CAP_W-1:0] capOut;

  learn_qualifier uut (
    .clk(clk), .srstN(srstN), .ramCorrupt(ramCorrupt), .nacIn(nacIn), .lmdIn(lmdIn),
    .cacIn(cacIn), .designCap(designCap), .edv1(edv1), .tempIn(tempIn),
    .avgCur(avgCur), .standbyCur(standbyCur), .chgTick(chgTick), .sdTick(sdTick),
    .dsgTick(dsgTick), .cycleTick(cycleTick), .validDsg(validDsg),
    .capInacc(capInacc), .capOut(capOut), .capStrobe(capStrobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  string curReq = "R7";
  bit cmpOn = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  int mVdq = 0, mCi = 0, mCap = 0, mStb = 0, mChg = 0, mSd = 0, mAcc = 0, mCyc = 0, mEdvp = 0;
  always @(posedge clk) begin
    bit ok;
    bit finished;
    int floorV;
    finished = 0;
    if (!srstN) begin
      mVdq = 0; mChg = 0; mSd = 0; mAcc = 0; mStb = 0; mEdvp = 0; mCap = 0;
      if (ramCorrupt) begin mCi = 1; mCyc = 0; end
    end else begin
      mStb = 0;
      if (mVdq == 1 && edv1 && mEdvp == 0) begin
        ok = (tempIn >= 0) && (int'(avgCur) > 2 * int'(standbyCur))
             && !(chgTick && mChg == 255) && !(sdTick && mSd == 63)
             && !(sdTick && int'(cacIn) <= int'(designCap) / 16);
        mVdq = 0;
        if (ok) begin
          floorV = int'(lmdIn) - int'(designCap) / 8;
          if (floorV < 0) floorV = 0;
          mCap = (mAcc > floorV) ? mAcc : floorV;
          mStb = 1; mCi = 0; mCyc = 0; finished = 1;
        end
      end else if (mVdq == 1) begin
        if (chgTick) begin if (mChg == 255) mVdq = 0; else mChg++; end
        if (sdTick)  begin if (mSd == 63) mVdq = 0; else mSd++; end
        if (dsgTick && mAcc < 65535) mAcc++;
      end else if (nacIn == lmdIn) begin
        mVdq = 1; mChg = 0; mSd = 0; mAcc = 0;
      end
      if (!finished && cycleTick && mCyc < 32) begin
        mCyc++;
        if (mCyc == 32) mCi = 1;
      end
      mEdvp = edv1;
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      chk({curReq, " validDsg"}, validDsg, mVdq);
      chk({curReq, " capInacc"}, capInacc, mCi);
      chk({curReq, " capStrobe"}, capStrobe, mStb);
      chk({curReq, " capOut"}, capOut, mCap);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic armIt();
    nacIn = lmdIn; step(1); nacIn = lmdIn - 1;
    chk("R1 armed", validDsg, 1);
  endtask

  task automatic dsgN(int n);
    dsgTick = 1; step(n); dsgTick = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R13 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    srstN = 0; ramCorrupt = 1; nacIn = 0; lmdIn = 400; designCap = 800; cacIn = 300;
    edv1 = 0; tempIn = 25; avgCur = 100; standbyCur = 20;
    chgTick = 0; sdTick = 0; dsgTick = 0; cycleTick = 0;
    step(3);
    chk("R7 reset vdq", validDsg, 0);
    chk("R7 corrupt reset sets ci", capInacc, 1);
    chk("R7 reset cap", capOut, 0);
    srstN = 1; ramCorrupt = 0; cmpOn = 1;

    // R4 normal learn, R9 boundary current qualifies
    curReq = "R4"; avgCur = 41;
    armIt(); dsgN(350);
    edv1 = 1; step(1);
    chk("R2 strobe", capStrobe, 1); chk("R4 cap", capOut, 350);
    chk("R5 ci cleared", capInacc, 0); chk("R2 vdq ends", validDsg, 0);
    chk("R9 boundary qualifies", capStrobe, 1);
    edv1 = 0; step(1);
    chk("R2 strobe one cycle", capStrobe, 0);
    avgCur = 100;

    // R3 learn-down floor
    curReq = "R3";
    armIt(); dsgN(120); edv1 = 1; step(1);
    chk("R3 floor", capOut, 300); edv1 = 0; step(1);

    // R8 cold
    curReq = "R8"; tempIn = -5;
    armIt(); dsgN(200); edv1 = 1; step(1);
    chk("R8 no strobe", capStrobe, 0); chk("R13 cap kept", capOut, 300);
    edv1 = 0; tempIn = 25; step(1);

    // R9 light load
    curReq = "R9"; avgCur = 40;
    armIt(); dsgN(350); edv1 = 1; step(1);
    chk("R9 no strobe", capStrobe, 0); chk("R9 cap kept", capOut, 300);
    edv1 = 0; avgCur = 100; step(1);

    // R10 charge overflow
    curReq = "R10";
    armIt(); chgTick = 1; step(255); chgTick = 0;
    chk("R10 255 keeps", validDsg, 1);
    chgTick = 1; step(1); chgTick = 0;
    chk("R10 256 clears", validDsg, 0);
    edv1 = 1; step(1); chk("R13 unarmed no strobe", capStrobe, 0); edv1 = 0; step(1);

    // R11 self-discharge count
    curReq = "R11";
    armIt(); sdTick = 1; step(63); sdTick = 0;
    chk("R11 63 keeps", validDsg, 1);
    sdTick = 1; step(1); sdTick = 0;
    chk("R11 64 clears", validDsg, 0);

    // R12 self-discharge at ending
    curReq = "R12";
    armIt(); dsgN(350); cacIn = 50; sdTick = 1; edv1 = 1; step(1); sdTick = 0;
    chk("R12 low cac no strobe", capStrobe, 0); edv1 = 0; step(1);
    armIt(); dsgN(350); cacIn = 51; sdTick = 1; edv1 = 1; step(1); sdTick = 0;
    chk("R12 above limit publishes", capStrobe, 1); chk("R12 cap", capOut, 350);
    edv1 = 0; cacIn = 300; step(1);

    // R6 cycle counter
    curReq = "R6";
    cycleTick = 1; step(31); cycleTick = 0;
    chk("R6 31 ticks clear", capInacc, 0);
    cycleTick = 1; step(1); cycleTick = 0;
    chk("R6 32 ticks set", capInacc, 1);

    // R7 plain and corrupt resets
    curReq = "R7";
    armIt(); dsgN(350); edv1 = 1; step(1); edv1 = 0; step(1);
    chk("R5 ci cleared again", capInacc, 0);
    armIt(); srstN = 0; step(1);
    chk("R7 reset clears vdq", validDsg, 0); chk("R7 plain reset keeps ci", capInacc, 0);
    ramCorrupt = 1; step(1);
    chk("R7 corrupt sets ci", capInacc, 1);
    srstN = 1; ramCorrupt = 0; step(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule